// File: doc/BRIEF.md
# Exception Priority Sequencer

This block gathers exception requests for a simple in-order processor core. It decides which of them are taken and the order in which their stacking sequences begin. There are three request groups. The abort group holds reset, address error and bus error. The boundary group holds trace, interrupt, illegal opcode and privilege fault. The instruction group holds trap, trap-on-overflow, bounds check and divide by zero. The block hands the core one exception code per processing slot.

An abort-group request takes effect at once. It pulses the abort strobe and emits its code on the next cycle. The other requests are held in a sticky register. They are taken together only when the core signals an instruction boundary. When several are taken at once, they are started lowest priority first, so the handler of the highest-priority one runs first. The core acknowledges each stacking sequence before the next code is sent. A stall output tells the core not to begin the next instruction while a batch is in progress.

Top module: `exc_prio_seq`

## Requirements
- R1: Exception codes on `exc_code_o`: 1 reset, 2 address error, 3 bus error, 4 trace, 5 interrupt, 6 illegal opcode, 7 privilege fault, 8 trap, 9 trap-on-overflow, 10 bounds check, 11 divide by zero. The code is 0 whenever `exc_valid_o` is low.
- R2: When any abort-group request is sampled at a clock edge, `abort_o` and `exc_valid_o` are high in the following cycle. Only the highest of the simultaneous abort-group requests is emitted, ranked reset, then address error, then bus error. The lower ones are dropped.
- R3: An address or bus error cancels every pending instruction-group request, including one sampled in the same cycle. Pending boundary-group requests survive it.
- R4: A reset request clears every pending request and any batch in progress. After its own slot, nothing else is emitted until new requests arrive.
- R5: Non-abort requests are sticky. They are taken only when `boundary_i` is high while at least one is pending. A boundary with nothing pending has no effect.
- R6: Inside a batch the slots are emitted lowest priority first. The order is: the instruction-group exception, then privilege fault, then illegal opcode, then interrupt, then trace.
- R7: `exc_valid_o` is a one-cycle pulse. The next slot is emitted only in the cycle after `ack_i` is seen high while waiting. `ack_i` at any other time is ignored.
- R8: Non-abort requests that arrive while a batch is running are not added to it. They stay pending until the next boundary.
- R9: `hold_o` is high from a boundary that has pending requests until the acknowledge of the last slot. It is low when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_reset_i | input | 1 | Reset exception request |
| req_addr_err_i | input | 1 | Address error request |
| req_bus_err_i | input | 1 | Bus error request |
| req_trace_i | input | 1 | Trace request |
| req_irq_i | input | 1 | Interrupt request |
| req_illegal_i | input | 1 | Illegal opcode request |
| req_priv_i | input | 1 | Privilege fault request |
| req_trap_i | input | 1 | Trap request |
| req_trapv_i | input | 1 | Trap-on-overflow request |
| req_chk_i | input | 1 | Bounds check request |
| req_div0_i | input | 1 | Divide by zero request |
| boundary_i | input | 1 | Core is at an instruction boundary |
| ack_i | input | 1 | Core finished the current stacking sequence |
| abort_o | output | 1 | Abort current instruction (one cycle) |
| hold_o | output | 1 | Core must not start the next instruction |
| exc_valid_o | output | 1 | Exception slot strobe (one cycle) |
| exc_code_o | output | 4 | Code of the emitted exception |

## Verification
The hardest case to reach is a request that arrives in the middle of a batch. The block must keep it out of the running sequence, yet still take it at the next boundary. Directed stimulus injects an interrupt pulse while the sequencer waits for an acknowledge between two slots, then checks both the rest of the batch and the batch that follows. Abort-group requests are also fired on top of a full pending set, to show that instruction-group requests are cancelled while boundary-group ones survive. Random batches with random acknowledge delays cover the ordering rule.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CODE_W  = 4;
  localparam int SLOT_N  = 8;
  localparam int G2_N    = 4;
  localparam int SLOT_IW = $clog2(SLOT_N);

  typedef enum logic [CODE_W-1:0] {
    EXC_NONE    = 4'd0,
    EXC_RESET   = 4'd1,
    EXC_ADDR    = 4'd2,
    EXC_BUS     = 4'd3,
    EXC_TRACE   = 4'd4,
    EXC_IRQ     = 4'd5,
    EXC_ILLEGAL = 4'd6,
    EXC_PRIV    = 4'd7,
    EXC_TRAP    = 4'd8,
    EXC_TRAPV   = 4'd9,
    EXC_CHK     = 4'd10,
    EXC_DIV0    = 4'd11
  } exc_code_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} seq_st_e;

  // slot index is in emission order: lowest priority first
  function automatic exc_code_e slot_code(input logic [SLOT_IW-1:0] idx);
    case (idx)
      3'd0:    return EXC_TRAP;
      3'd1:    return EXC_TRAPV;
      3'd2:    return EXC_CHK;
      3'd3:    return EXC_DIV0;
      3'd4:    return EXC_PRIV;
      3'd5:    return EXC_ILLEGAL;
      3'd6:    return EXC_IRQ;
      default: return EXC_TRACE;
    endcase
  endfunction
endpackage

// File: rtl/exc_pending.sv
module exc_pending #(
  parameter int N  = 8,
  parameter int G2 = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         kill_all_i,
  input  logic         kill_g2_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_d;

  always_comb begin
    pend_d = (pend_o & ~clr_i) | set_i;
    if (kill_g2_i)  pend_d[G2-1:0] = '0;
    if (kill_all_i) pend_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= pend_d;
  end

  // R5: no bit becomes pending without a request
  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0) |=> ((pend_o & ~$past(pend_o)) == '0));
endmodule

// File: rtl/exc_pick.sv
module exc_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  in_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  logic [N:0] below;

  assign below[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_pfx
    assign below[g+1]  = below[g] | in_i[g];
    assign onehot_o[g] = in_i[g] & ~below[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
  end
endmodule

// File: rtl/exc_g0_arb.sv
module exc_g0_arb
  import exc_pkg::*;
(
  input  logic      reset_i,
  input  logic      addr_i,
  input  logic      bus_i,
  output logic      any_o,
  output exc_code_e code_o
);
  assign any_o = reset_i | addr_i | bus_i;

  always_comb begin
    if (reset_i)     code_o = EXC_RESET;
    else if (addr_i) code_o = EXC_ADDR;
    else if (bus_i)  code_o = EXC_BUS;
    else             code_o = EXC_NONE;
  end
endmodule

// File: rtl/exc_prio_seq.sv
module exc_prio_seq
  import exc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_reset_i,
  input  logic              req_addr_err_i,
  input  logic              req_bus_err_i,
  input  logic              req_trace_i,
  input  logic              req_irq_i,
  input  logic              req_illegal_i,
  input  logic              req_priv_i,
  input  logic              req_trap_i,
  input  logic              req_trapv_i,
  input  logic              req_chk_i,
  input  logic              req_div0_i,
  input  logic              boundary_i,
  input  logic              ack_i,
  output logic              abort_o,
  output logic              hold_o,
  output logic              exc_valid_o,
  output logic [CODE_W-1:0] exc_code_o
);
  logic [SLOT_N-1:0]  req_vec, pend_q, snap_q, pick_oh, clr_vec;
  logic [SLOT_IW-1:0] pick_idx;
  logic               g0_any, abort_q, emit_batch;
  exc_code_e          g0_code, g0_q;
  seq_st_e            st_q;

  // slot order = emission order, lowest priority first
  assign req_vec = {req_trace_i, req_irq_i, req_illegal_i, req_priv_i,
                    req_div0_i, req_chk_i, req_trapv_i, req_trap_i};

  exc_g0_arb u_g0 (
    .reset_i (req_reset_i),
    .addr_i  (req_addr_err_i),
    .bus_i   (req_bus_err_i),
    .any_o   (g0_any),
    .code_o  (g0_code)
  );

  exc_pick #(.N(SLOT_N)) u_pick (
    .in_i     (snap_q),
    .onehot_o (pick_oh),
    .idx_o    (pick_idx)
  );

  assign emit_batch = (st_q == ST_SEND) && (g0_q == EXC_NONE);
  assign clr_vec    = emit_batch ? pick_oh : '0;

  exc_pending #(.N(SLOT_N), .G2(G2_N)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (req_vec),
    .clr_i      (clr_vec),
    .kill_all_i (req_reset_i),
    .kill_g2_i  (req_addr_err_i | req_bus_err_i),
    .pend_o     (pend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      snap_q  <= '0;
      g0_q    <= EXC_NONE;
      abort_q <= 1'b0;
    end else begin
      abort_q <= g0_any;
      if (g0_any) begin
        // abort path preempts any batch
        g0_q   <= g0_code;
        snap_q <= '0;
        st_q   <= ST_SEND;
      end else begin
        unique case (st_q)
          ST_IDLE: if (boundary_i && (pend_q != '0)) begin
            snap_q <= pend_q;
            st_q   <= ST_SEND;
          end
          ST_SEND: begin
            if (g0_q != EXC_NONE) g0_q <= EXC_NONE;
            else                  snap_q <= snap_q & ~pick_oh;
            st_q <= ST_WAIT;
          end
          ST_WAIT: if (ack_i) st_q <= (snap_q != '0) ? ST_SEND : ST_IDLE;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign abort_o     = abort_q;
  assign exc_valid_o = (st_q == ST_SEND);
  assign exc_code_o  = !exc_valid_o         ? EXC_NONE :
                       (g0_q != EXC_NONE)   ? g0_q     : slot_code(pick_idx);
  assign hold_o      = (st_q != ST_IDLE) || (boundary_i && (pend_q != '0));

  a_r2_abort_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_reset_i || req_addr_err_i || req_bus_err_i) |=> (abort_o && exc_valid_o));
  a_r2_reset_rank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_reset_i |=> (exc_code_o == EXC_RESET));
  a_r2_addr_rank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_addr_err_i && !req_reset_i) |=> (exc_code_o == EXC_ADDR));
  a_r3_g2_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_addr_err_i || req_bus_err_i) |=> (pend_q[G2_N-1:0] == '0));
  a_r4_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_reset_i |=> (pend_q == '0));
  a_r7_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o && !g0_any) |=> !exc_valid_o);
  a_r7_need_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_valid_o && !ack_i && !g0_any && !boundary_i) |=> !exc_valid_o);
  a_r9_hold_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> hold_o);
endmodule

// File: tb/exc_prio_seq_tb_top.sv
module exc_prio_seq_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic rst_r = 0, addr_r = 0, bus_r = 0, boundary = 0, ack = 0;
  logic [7:0] rq = '0; // {trace,irq,illegal,priv,div0,chk,trapv,trap}
  logic abort, hold, valid;
  logic [3:0] code;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  exc_prio_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_reset_i(rst_r), .req_addr_err_i(addr_r), .req_bus_err_i(bus_r),
    .req_trace_i(rq[7]), .req_irq_i(rq[6]), .req_illegal_i(rq[5]), .req_priv_i(rq[4]),
    .req_trap_i(rq[0]), .req_trapv_i(rq[1]), .req_chk_i(rq[2]), .req_div0_i(rq[3]),
    .boundary_i(boundary), .ack_i(ack),
    .abort_o(abort), .hold_o(hold), .exc_valid_o(valid), .exc_code_o(code)
  );

  // R1 code table, indexed in R6 emission order
  function automatic int exp_code(int slot);
    int t[8] = '{8, 9, 10, 11, 7, 6, 5, 4};
    return t[slot];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse(logic [7:0] m);
    rq = m; tick(); rq = '0;
  endtask

  task automatic expect_slot(int c, string req);
    chk(valid === 1'b1, {req, " valid"}, valid, 1);
    chk(code == 4'(c), {req, " code"}, code, c);
    tick();
    chk(valid === 1'b0, "R7 pulse width", valid, 0);
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic run_batch(logic [7:0] m, int max_dly);
    boundary = 1; #1;
    chk(hold === (m != 0), "R9 hold at boundary", hold, int'(m != 0));
    tick(); boundary = 0;
    if (m == 0) begin
      chk(valid === 1'b0, "R5 empty boundary", valid, 0);
      return;
    end
    for (int i = 0; i < 8; i++) begin
      if (m[i]) begin
        expect_slot(exp_code(i), "R6");
        for (int d = $urandom_range(max_dly, 0); d > 0; d--) begin
          tick();
          chk(valid === 1'b0, "R7 wait for ack", valid, 0);
          chk(hold === 1'b1, "R9 hold in batch", hold, 1);
        end
        do_ack();
      end
    end
    chk(hold === 1'b0, "R9 hold after batch", hold, 0);
    chk(valid === 1'b0, "R6 batch end", valid, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    tick();
    chk(valid === 0 && abort === 0 && hold === 0, "R7 reset state", {valid, abort, hold}, 0);
    chk(code == 0, "R1 idle code", code, 0);

    // R5 boundary with nothing pending, R7 stray ack
    run_batch(8'h00, 0);
    ack = 1; tick(); ack = 0; tick();
    chk(valid === 1'b0, "R7 stray ack ignored", valid, 0);

    // R6 trap, trace, interrupt together
    pulse(8'b1100_0001);
    tick();
    chk(valid === 1'b0, "R5 sticky until boundary", valid, 0);
    run_batch(8'b1100_0001, 2);

    // R8 request during batch held to next boundary
    pulse(8'b0001_0001);
    boundary = 1; tick(); boundary = 0;
    expect_slot(8, "R8 first");
    pulse(8'b0100_0000);
    do_ack();
    expect_slot(7, "R8 rest of batch");
    do_ack();
    chk(valid === 1'b0 && hold === 1'b0, "R8 batch closed", hold, 0);
    run_batch(8'b0100_0000, 1);

    // R3 bus error cancels trap, keeps interrupt
    pulse(8'b0100_0001);
    bus_r = 1; tick(); bus_r = 0;
    chk(abort === 1'b1, "R2 abort", abort, 1);
    chk(valid === 1'b1 && code == 3, "R2 bus code", code, 3);
    tick();
    chk(abort === 1'b0 && valid === 1'b0, "R2 abort pulse", abort, 0);
    do_ack();
    run_batch(8'b0100_0000, 1);

    // R2 addr over bus, R3 same-cycle trapv cancelled
    addr_r = 1; bus_r = 1; rq = 8'b0000_0010; tick();
    addr_r = 0; bus_r = 0; rq = '0;
    chk(valid === 1'b1 && code == 2, "R2 addr over bus", code, 2);
    tick(); do_ack();
    repeat (2) begin
      tick();
      chk(valid === 1'b0, "R2 bus dropped", valid, 0);
    end
    run_batch(8'h00, 0);

    // R4 reset clears pending
    pulse(8'b1000_0100);
    rst_r = 1; bus_r = 1; tick(); rst_r = 0; bus_r = 0;
    chk(valid === 1'b1 && code == 1, "R4 reset code", code, 1);
    chk(abort === 1'b1, "R4 reset abort", abort, 1);
    tick(); do_ack();
    run_batch(8'h00, 0);

    // R4 reset during a batch
    pulse(8'b1110_0000);
    boundary = 1; tick(); boundary = 0;
    expect_slot(6, "R4 batch start");
    rst_r = 1; tick(); rst_r = 0;
    chk(valid === 1'b1 && code == 1, "R4 reset preempts", code, 1);
    tick(); do_ack();
    chk(hold === 1'b0, "R4 batch dropped", hold, 0);
    run_batch(8'h00, 0);

    // random batches
    for (int k = 0; k < 60; k++) begin
      logic [7:0] m;
      int g2, g1b;
      m = '0;
      m[7] = 1'($urandom_range(1, 0));
      m[6] = 1'($urandom_range(1, 0));
      g1b = $urandom_range(2, 0);
      if (g1b == 1) m[4] = 1; else if (g1b == 2) m[5] = 1;
      g2 = $urandom_range(4, 0);
      if (g2 != 0) m[g2-1] = 1;
      for (int i = 0; i < 8; i++)
        if (m[i]) pulse(8'(1 << i));
      run_batch(m, 3);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule